// File: doc/BRIEF.md
# 8-bit Arithmetic and Logic Unit with Condition Flags

This unit is purely combinational. It holds the arithmetic and logic of a small 8-bit processor datapath. Each cycle the surrounding core presents an operation code, a register operand `a`, a memory operand `m`, the current carry bit and the decimal-mode bit. In the same cycle the unit returns the computed byte. It also returns fresh values for the negative, overflow, zero and carry flags, and a write mask that says which of those flags and whether the result byte should be committed. Registers, instruction sequencing and bus traffic belong to the caller.

The unit covers binary and packed-BCD add and subtract, the three bitwise operations, a pass-through used for register transfers, compare, bit test, shifts and rotates through carry, and increment and decrement. Compare and bit test produce flags only. Subtraction uses the carry as an inverted borrow.

Top module: `alu8_core`

## Requirements
- R1: Opcode 0 (add), binary mode: result is (a + m + carry_in) mod 256, flag_c is the carry out of bit 7, and flag_we is 4'b1111.
- R2: Opcode 1 (subtract), binary mode: result is (a - m - (1 - carry_in)) mod 256, flag_c is 1 exactly when no borrow occurred, and flag_we is 4'b1111.
- R3: For opcodes 0 and 1, flag_v is 1 when the operands as seen by the adder (m inverted for subtract) share a sign and the sign of the result differs from it.
- R4: With decimal high, opcodes 0 and 1 work per 4-bit BCD digit (0x09 + 0x01 gives 0x10). flag_c is the decimal carry out of the top digit, or "no decimal borrow" for subtract. flag_n, flag_v and flag_z follow the binary result of the same inputs.
- R5: Opcodes 2, 3, 4 and 13 give a AND m, a OR m, a XOR m and m (transfer). Only N and Z are written (flag_we 4'b1010).
- R6: Opcode 5 (compare) ignores decimal and sets flag_n = (a < m), flag_z = (a == m), flag_c = (a >= m). flag_we is 4'b1011 and res_we is 0.
- R7: Opcode 6 (bit test) sets flag_z = ((a AND m) == 0), flag_n = m[7] and flag_v = m[6]. flag_we is 4'b1110 and res_we is 0.
- R8: Opcode 7 shifts a left, bringing in 0, with flag_c = a[7]. Opcode 8 shifts a right, bringing in 0, with flag_c = a[0]. flag_we is 4'b1011 for both.
- R9: Opcodes 9 and 10 rotate a left and right through the carry. carry_in fills the vacated bit and the bit shifted out goes to flag_c. flag_we is 4'b1011.
- R10: Opcodes 11 and 12 return a + 1 and a - 1 modulo 256. flag_we is 4'b1010.
- R11: flag_we bits are ordered {N, V, Z, C} from bit 3 down to bit 0. Opcodes 14 and 15 set res_we to 0 and flag_we to 0.
- R12: For every operation that writes a result, other than the decimal arithmetic of R4, flag_n equals result bit 7 and flag_z is 1 exactly when the result is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op | input | 4 | Operation code |
| a | input | 8 | Register operand |
| m | input | 8 | Memory operand |
| carry_in | input | 1 | Current carry flag |
| decimal | input | 1 | BCD mode for add and subtract |
| result | output | 8 | Computed byte |
| res_we | output | 1 | Result should be written back |
| flag_n | output | 1 | Next negative flag |
| flag_v | output | 1 | Next overflow flag |
| flag_z | output | 1 | Next zero flag |
| flag_c | output | 1 | Next carry flag |
| flag_we | output | 4 | Flag write mask {N,V,Z,C} |

## Verification
There are no registers, so a fault in the digit carry chain, the operand inversion or the opcode decode shows at the ports in the same cycle. It appears as a wrong byte, a wrong flag value or a wrong write mask. A stale or misrouted decimal carry only shows for operands whose low digit wraps, so such digit-boundary values are applied on purpose. A decode fault that leaves a flag's mask bit set for an operation that should not touch it is caught by comparing the whole mask on every operation, not only the flags that are expected to change.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_AND  = 4'd2,
    OP_OR   = 4'd3,
    OP_XOR  = 4'd4,
    OP_CMP  = 4'd5,
    OP_BIT  = 4'd6,
    OP_SHL  = 4'd7,
    OP_SHR  = 4'd8,
    OP_ROL  = 4'd9,
    OP_ROR  = 4'd10,
    OP_INC  = 4'd11,
    OP_DEC  = 4'd12,
    OP_PASS = 4'd13,
    OP_RS14 = 4'd14,
    OP_RS15 = 4'd15
  } alu_op_e;

  typedef enum logic [1:0] {
    LG_AND  = 2'd0,
    LG_OR   = 2'd1,
    LG_XOR  = 2'd2,
    LG_PASS = 2'd3
  } logic_sel_e;

  // One BCD digit of an addition: returns {carry_out, digit}.
  function automatic logic [4:0] bcd_add_digit(input logic [3:0] x,
                                               input logic [3:0] y,
                                               input logic       ci);
    logic [4:0] s;
    s = {1'b0, x} + {1'b0, y} + {4'b0, ci};
    if (s > 5'd9) return {1'b1, s[3:0] + 4'd6};
    return {1'b0, s[3:0]};
  endfunction

  // One BCD digit of a subtraction: nbi is "no borrow in";
  // returns {no_borrow_out, digit}.
  function automatic logic [4:0] bcd_sub_digit(input logic [3:0] x,
                                               input logic [3:0] y,
                                               input logic       nbi);
    logic [4:0] d;
    d = {1'b0, x} - {1'b0, y} - {4'b0, ~nbi};
    if (d[4]) return {1'b0, d[3:0] - 4'd6};
    return {1'b1, d[3:0]};
  endfunction

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub import alu8_pkg::*; #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] m,
  input  logic         cin,
  input  logic         sub,
  input  logic         dec,
  output logic [W-1:0] res,
  output logic [W-1:0] bin_res,
  output logic         cout,
  output logic         ovf
);
  localparam int DIG = W / 4;

  logic [W-1:0] m_eff;
  logic [W:0]   bin_full;
  logic [W-1:0] dec_res;
  logic [DIG:0] dchain;

  assign dchain[0] = cin;

  generate
    for (genvar g = 0; g < DIG; g++) begin : g_digit
      logic [4:0] dg;
      assign dg = sub ? bcd_sub_digit(a[4*g +: 4], m[4*g +: 4], dchain[g])
                      : bcd_add_digit(a[4*g +: 4], m[4*g +: 4], dchain[g]);
      assign dec_res[4*g +: 4] = dg[3:0];
      assign dchain[g+1]       = dg[4];
    end
  endgenerate

  always_comb begin
    m_eff    = sub ? ~m : m;
    bin_full = {1'b0, a} + {1'b0, m_eff} + {{W{1'b0}}, cin};
    bin_res  = bin_full[W-1:0];
    ovf      = (a[W-1] == m_eff[W-1]) && (bin_full[W-1] != a[W-1]);
    res      = dec ? dec_res : bin_res;
    cout     = dec ? dchain[DIG] : bin_full[W];
  end

  function automatic logic all_bcd(input logic [W-1:0] v);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < DIG; i++) if (v[4*i +: 4] > 4'd9) ok = 1'b0;
    return ok;
  endfunction

  // R4: valid BCD operands must yield valid BCD digits
  always_comb begin
    if (dec && all_bcd(a) && all_bcd(m))
      assert_bcd_digits_R4: assert (all_bcd(res));
  end

endmodule

// File: rtl/alu8_logic.sv
module alu8_logic import alu8_pkg::*; #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] m,
  input  logic [1:0]   sel,
  output logic [W-1:0] res
);
  always_comb begin
    case (logic_sel_e'(sel))
      LG_AND:  res = a & m;
      LG_OR:   res = a | m;
      LG_XOR:  res = a ^ m;
      default: res = m;
    endcase
  end

  // R5: an AND never sets a bit that the register operand lacks
  always_comb begin
    if (sel == LG_AND) assert_and_subset_R5: assert ((res & ~a) == '0);
    if (sel == LG_OR)  assert_or_superset_R5: assert ((res & a) == a);
  end
endmodule

// File: rtl/alu8_shifter.sv
module alu8_shifter #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic         cin,
  input  logic         left,
  input  logic         rotate,
  output logic [W-1:0] res,
  output logic         cout
);
  logic fill;

  always_comb begin
    fill = rotate & cin;
    if (left) begin
      res  = {a[W-2:0], fill};
      cout = a[W-1];
    end else begin
      res  = {fill, a[W-1:1]};
      cout = a[0];
    end
  end

  // R8/R9: bits are conserved across result and carry
  always_comb begin
    if (rotate)
      assert_rot_conserve_R9: assert ($countones(res) + 32'(cout) ==
                                      $countones(a) + 32'(cin));
    else
      assert_shift_conserve_R8: assert ($countones(res) + 32'(cout) ==
                                        $countones(a));
  end
endmodule

// File: rtl/alu8_core.sv
module alu8_core import alu8_pkg::*; #(
  parameter int W = 8
) (
  input  logic [3:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] m,
  input  logic         carry_in,
  input  logic         decimal,
  output logic [W-1:0] result,
  output logic         res_we,
  output logic         flag_n,
  output logic         flag_v,
  output logic         flag_z,
  output logic         flag_c,
  output logic [3:0]   flag_we
);
  localparam int SGN = W - 1;

  alu_op_e opc;
  assign opc = alu_op_e'(op);

  // named decode events
  logic is_arith, is_logic, is_cmp, is_bit, is_shift, is_incdec;
  always_comb begin
    is_arith  = (opc == OP_ADD) || (opc == OP_SUB);
    is_logic  = (opc == OP_AND) || (opc == OP_OR) || (opc == OP_XOR) ||
                (opc == OP_PASS);
    is_cmp    = (opc == OP_CMP);
    is_bit    = (opc == OP_BIT);
    is_shift  = (opc == OP_SHL) || (opc == OP_SHR) || (opc == OP_ROL) ||
                (opc == OP_ROR);
    is_incdec = (opc == OP_INC) || (opc == OP_DEC);
  end

  // adder / subtractor, shared with compare
  logic         as_sub, as_cin, as_dec, as_cout, as_ovf;
  logic [W-1:0] as_res, as_bin;
  assign as_sub = (opc == OP_SUB) || is_cmp;
  assign as_cin = is_cmp ? 1'b1 : carry_in;
  assign as_dec = decimal && is_arith;

  alu8_addsub #(.W(W)) u_addsub (
    .a(a), .m(m), .cin(as_cin), .sub(as_sub), .dec(as_dec),
    .res(as_res), .bin_res(as_bin), .cout(as_cout), .ovf(as_ovf)
  );

  // bitwise unit, also serves bit test
  logic [1:0]   lg_sel;
  logic [W-1:0] lg_res;
  always_comb begin
    case (opc)
      OP_OR:   lg_sel = LG_OR;
      OP_XOR:  lg_sel = LG_XOR;
      OP_PASS: lg_sel = LG_PASS;
      default: lg_sel = LG_AND;
    endcase
  end

  alu8_logic #(.W(W)) u_logic (.a(a), .m(m), .sel(lg_sel), .res(lg_res));

  // shifter
  logic         sh_left, sh_rot, sh_cout;
  logic [W-1:0] sh_res;
  assign sh_left = (opc == OP_SHL) || (opc == OP_ROL);
  assign sh_rot  = (opc == OP_ROL) || (opc == OP_ROR);

  alu8_shifter #(.W(W)) u_shift (
    .a(a), .cin(carry_in), .left(sh_left), .rotate(sh_rot),
    .res(sh_res), .cout(sh_cout)
  );

  logic [W-1:0] id_res;
  assign id_res = (opc == OP_INC) ? a + 1'b1 : a - 1'b1;

  // result and flag assembly; mask order is {N,V,Z,C}
  always_comb begin
    result  = '0;
    res_we  = 1'b0;
    flag_n  = 1'b0;
    flag_v  = 1'b0;
    flag_z  = 1'b0;
    flag_c  = 1'b0;
    flag_we = 4'b0000;
    if (is_arith) begin
      result  = as_res;
      res_we  = 1'b1;
      flag_n  = as_bin[SGN];
      flag_z  = (as_bin == '0);
      flag_v  = as_ovf;
      flag_c  = as_cout;
      flag_we = 4'b1111;
    end else if (is_cmp) begin
      flag_n  = ~as_cout;
      flag_z  = (as_bin == '0);
      flag_c  = as_cout;
      flag_we = 4'b1011;
    end else if (is_bit) begin
      flag_n  = m[SGN];
      flag_v  = m[SGN-1];
      flag_z  = (lg_res == '0);
      flag_we = 4'b1110;
    end else if (is_logic || is_incdec) begin
      result  = is_logic ? lg_res : id_res;
      res_we  = 1'b1;
      flag_n  = result[SGN];
      flag_z  = (result == '0);
      flag_we = 4'b1010;
    end else if (is_shift) begin
      result  = sh_res;
      res_we  = 1'b1;
      flag_n  = sh_res[SGN];
      flag_z  = (sh_res == '0);
      flag_c  = sh_cout;
      flag_we = 4'b1011;
    end
  end

  // checks tying sub-unit outputs to the operands
  always_comb begin
    assert_class_onehot_R11: assert ($onehot0({is_arith, is_logic, is_cmp,
                                               is_bit, is_shift, is_incdec}));
    if (is_cmp)
      assert_cmp_carry_R6: assert (flag_c == (a >= m));
    if (is_bit)
      assert_bit_zero_R7: assert (flag_z == ((a & m) == '0));
    if (is_arith && !decimal)
      assert_bin_zero_R12: assert (flag_z == (result == '0));
    if (!res_we)
      assert_no_result_R11: assert (result == '0);
  end

endmodule

// File: tb/alu8_core_tb.sv
`timescale 1ns/1ps
module alu8_core_tb;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [3:0] op;
  logic [7:0] a, m, result;
  logic       carry_in, decimal, res_we, flag_n, flag_v, flag_z, flag_c;
  logic [3:0] flag_we;

  alu8_core #(.W(8)) u_dut (
    .op(op), .a(a), .m(m), .carry_in(carry_in), .decimal(decimal),
    .result(result), .res_we(res_we), .flag_n(flag_n), .flag_v(flag_v),
    .flag_z(flag_z), .flag_c(flag_c), .flag_we(flag_we)
  );

  typedef struct {
    logic [3:0] op;
    logic [7:0] a, m;
    logic       c, d;
    logic [7:0] res;
    logic       rwe;
    logic [3:0] we;
    logic       n, v, z, cf;
  } item_t;

  item_t q[$];
  int total = 0;
  int bad   = 0;
  bit done  = 0;

  function automatic string tag_of(input item_t e);
    if (e.op <= 1 && e.d) return "R4";
    case (e.op)
      0: return "R1";
      1: return "R2";
      2, 3, 4, 13: return "R5";
      5: return "R6";
      6: return "R7";
      7, 8: return "R8";
      9, 10: return "R9";
      11, 12: return "R10";
      default: return "R11";
    endcase
  endfunction

  // behavioural reference written from the requirements
  function automatic item_t model(input logic [3:0] o, input logic [7:0] x,
                                  input logic [7:0] y, input logic c,
                                  input logic d);
    item_t e;
    int s, lo, hi, bl;
    logic [7:0] bin;
    e.op = o; e.a = x; e.m = y; e.c = c; e.d = d;
    e.res = 8'h00; e.rwe = 0; e.we = 4'b0000;
    e.n = 0; e.v = 0; e.z = 0; e.cf = 0;
    case (o)
      0, 1: begin
        e.rwe = 1; e.we = 4'b1111;
        if (o == 0) begin
          s = int'(x) + int'(y) + int'(c);
          bin = 8'(s);
          e.cf = (s > 255);
          e.v = (((x ^ bin) & (y ^ bin) & 8'h80) != 0);
        end else begin
          s = int'(x) - int'(y) - (1 - int'(c));
          bin = 8'(s);
          e.cf = (s >= 0);
          e.v = (((x ^ y) & (x ^ bin) & 8'h80) != 0);
        end
        e.res = bin;
        e.n = bin[7];
        e.z = (bin == 0);
        if (d) begin
          if (o == 0) begin
            lo = int'(x & 15) + int'(y & 15) + int'(c);
            if (lo > 9) lo += 6;
            hi = int'(x >> 4) + int'(y >> 4) + ((lo > 15) ? 1 : 0);
            if (hi > 9) hi += 6;
            e.cf = (hi > 15);
          end else begin
            lo = int'(x & 15) - int'(y & 15) - (1 - int'(c));
            bl = (lo < 0) ? 1 : 0;
            if (lo < 0) lo -= 6;
            hi = int'(x >> 4) - int'(y >> 4) - bl;
            e.cf = (hi >= 0);
            if (hi < 0) hi -= 6;
          end
          e.res = {4'(hi & 15), 4'(lo & 15)};
        end
      end
      2, 3, 4, 13, 11, 12: begin
        e.rwe = 1; e.we = 4'b1010;
        case (o)
          2: e.res = x & y;
          3: e.res = x | y;
          4: e.res = x ^ y;
          13: e.res = y;
          11: e.res = 8'(int'(x) + 1);
          default: e.res = 8'(int'(x) + 255);
        endcase
        e.n = e.res[7]; e.z = (e.res == 0);
      end
      5: begin
        e.we = 4'b1011;
        e.n = (x < y); e.z = (x == y); e.cf = (x >= y);
      end
      6: begin
        e.we = 4'b1110;
        e.n = y[7]; e.v = y[6]; e.z = ((x & y) == 0);
      end
      7, 8, 9, 10: begin
        e.rwe = 1; e.we = 4'b1011;
        if (o == 7 || o == 9) begin
          e.res = {x[6:0], (o == 9) ? c : 1'b0};
          e.cf = x[7];
        end else begin
          e.res = {(o == 10) ? c : 1'b0, x[7:1]};
          e.cf = x[0];
        end
        e.n = e.res[7]; e.z = (e.res == 0);
      end
      default: ;
    endcase
    return e;
  endfunction

  task automatic drive(input logic [3:0] o, input logic [7:0] x,
                       input logic [7:0] y, input logic c, input logic d);
    @(posedge clk);
    #1;
    op = o; a = x; m = y; carry_in = c; decimal = d;
    q.push_back(model(o, x, y, c, d));
  endtask

  task automatic fail(input string t, input string what, input int act,
                      input int exp);
    bad++;
    $display("FAIL %s %s actual=%0h expected=%0h", t, what, act, exp);
  endtask

  // monitor: pops one expected item per cycle at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        item_t e;
        string t;
        e = q.pop_front();
        t = tag_of(e);
        total++;
        if (res_we !== e.rwe) fail(t, "res_we", int'(res_we), int'(e.rwe));
        if (e.rwe && result !== e.res) fail(t, "result", int'(result), int'(e.res));
        if (flag_we !== e.we) fail(t, "flag_we", int'(flag_we), int'(e.we));
        if (e.we[3] && flag_n !== e.n)
          fail((e.rwe && !e.d && e.op >= 2) ? "R12" : t, "N", int'(flag_n), int'(e.n));
        if (e.we[2] && flag_v !== e.v)
          fail((e.op <= 1) ? "R3" : t, "V", int'(flag_v), int'(e.v));
        if (e.we[1] && flag_z !== e.z)
          fail((e.rwe && !e.d && e.op >= 2) ? "R12" : t, "Z", int'(flag_z), int'(e.z));
        if (e.we[0] && flag_c !== e.cf) fail(t, "C", int'(flag_c), int'(e.cf));
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    op = 4'd14; a = 0; m = 0; carry_in = 0; decimal = 0;
    // idle state: reserved code writes nothing (R11)
    drive(4'd14, 8'hFF, 8'hFF, 1, 1);
    drive(4'd15, 8'h12, 8'h34, 0, 0);
    // R1 / R3 binary add corners
    drive(0, 8'h7F, 8'h01, 0, 0);
    drive(0, 8'hFF, 8'h01, 0, 0);
    drive(0, 8'h80, 8'h80, 1, 0);
    // R2 / R3 subtract corners
    drive(1, 8'h80, 8'h01, 1, 0);
    drive(1, 8'h00, 8'h01, 1, 0);
    drive(1, 8'h05, 8'h05, 0, 0);
    // R4 decimal cases
    drive(0, 8'h09, 8'h01, 0, 1);
    drive(0, 8'h99, 8'h01, 0, 1);
    drive(0, 8'h58, 8'h46, 1, 1);
    drive(1, 8'h00, 8'h01, 1, 1);
    drive(1, 8'h40, 8'h13, 0, 1);
    // R6 compare: less, equal, greater, less with high bit
    drive(5, 8'h10, 8'h20, 0, 1);
    drive(5, 8'h33, 8'h33, 0, 0);
    drive(5, 8'h90, 8'h10, 1, 0);
    drive(5, 8'h00, 8'h90, 0, 0);
    // R7 bit test
    drive(6, 8'h0F, 8'hF0, 0, 0);
    drive(6, 8'h01, 8'h41, 1, 0);
    // R8 / R9 shifts and rotates
    drive(7, 8'h80, 8'h00, 1, 0);
    drive(8, 8'h01, 8'h00, 1, 0);
    drive(9, 8'h80, 8'h00, 1, 0);
    drive(10, 8'h01, 8'h00, 1, 0);
    // R10 wrap
    drive(11, 8'hFF, 8'h00, 0, 0);
    drive(12, 8'h00, 8'h00, 0, 0);
    // R5 / R12 logic and transfer
    drive(2, 8'hF0, 8'h0F, 0, 0);
    drive(4, 8'hAA, 8'h55, 0, 0);
    drive(13, 8'h00, 8'h80, 0, 0);
    for (int i = 0; i < 4000; i++)
      drive(4'($urandom), 8'($urandom), 8'($urandom), 1'($urandom), 1'($urandom));
    @(posedge clk);
    @(negedge clk);
    @(posedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule